// File: doc/BRIEF.md
# Dual-Sequence ADC Conversion Sequencer

This block schedules conversions on an external analog-to-digital converter for two independent sequences, A and B. Each sequence has its own channel-enable mask and its own controls for continuous (burst) operation, one-channel-per-trigger stepping and flag timing. Sequence A also has a priority setting. The block sends a one-cycle start pulse with a channel number to the converter. The converter later returns a done pulse and a 12-bit result. The block can also cancel a conversion that is still in flight.

Each result is stored in a per-channel result register and in a global data register that belongs to the sequence that produced it. The global data register keeps valid and overrun bits. Each sequence raises a flag either after every conversion or once per completed pass, depending on its mode. An overrun interrupt combines the overruns of the sequences that are in per-conversion mode. When sequence A is set to high priority, a start for sequence B cancels the A conversion that is running. B then runs its full pass, and A afterwards picks up again from the cancelled channel.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, no conversion is started. Both flags, the overrun interrupt, the valid bits and the overrun bits are 0. For both sequences the mask is empty, burst and stepping are off, the flag mode is per-conversion and A has low priority.
- R2: A start on a sequence with a non-empty mask converts each enabled channel exactly once, in ascending channel index. Each conversion is announced by a one-cycle `cnv_start` pulse with the channel on `cnv_chan`.
- R3: A start on a sequence whose mask is empty is ignored, and no conversion is issued.
- R4: A start on a sequence whose pass is still under way is ignored. The pass is not restarted or lengthened.
- R5: With burst set, a sequence begins a new pass automatically after each pass ends, and its start input has no effect. When burst is cleared, the pass under way completes, so the last channel converted is the highest enabled one, and then conversions stop.
- R6: With stepping set, each start converts only the next enabled channel. After the highest enabled channel, the next start converts the lowest enabled channel again.
- R7: While A has low priority and an A pass is under way, a B start is discarded. No conversion is cancelled, and B converts nothing.
- R8: While A has high priority and is under way with a conversion in flight, a B start raises `cnv_abort` in the same cycle, and B's first conversion starts in the next cycle. After B's pass, A converts the cancelled channel again and then its remaining channels.
- R9: Each finished conversion writes the result and the channel into its sequence's global data register and sets valid. If valid was already set, overrun is also set. A `gdat_rd` pulse clears valid and overrun of the sequence picked by `gdat_sel` (0 = A, 1 = B).
- R10: In per-conversion mode (flag mode 0), a sequence's flag equals its global valid bit, and its global overrun drives `ovr_irq`.
- R11: In per-pass mode (flag mode 1), the flag is set when the last enabled channel of a pass (or step) finishes. It stays set until that sequence's `flag_clr` bit is pulsed, and the sequence's global overrun does not drive `ovr_irq`.
- R12: The per-channel result register selected by `res_sel` holds the last result converted on that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for one sequence's controls |
| cfg_sel | input | 1 | Sequence written: 0 = A, 1 = B |
| cfg_mask | input | NCH | Channel-enable mask |
| cfg_burst | input | 1 | Continuous pass repetition |
| cfg_step | input | 1 | One channel per start |
| cfg_hiprio | input | 1 | A high priority (used only when A is written) |
| cfg_eos | input | 1 | Flag mode: 0 per conversion, 1 per pass |
| start_a | input | 1 | Start pulse for sequence A (hardware or software) |
| start_b | input | 1 | Start pulse for sequence B |
| flag_clr | input | 2 | Per-sequence flag clear (bit 0 = A) |
| gdat_sel | input | 1 | Global data register view select |
| gdat_rd | input | 1 | Read strobe, clears valid and overrun of the selected sequence |
| gdat_data | output | RW | Last result of the selected sequence |
| gdat_chan | output | CW | Channel of that result |
| gdat_valid | output | 1 | Result not yet read |
| gdat_ovr | output | 1 | Result overwritten before being read |
| seq_flag | output | 2 | Per-sequence interrupt/DMA flag (bit 0 = A) |
| ovr_irq | output | 1 | Overrun interrupt |
| res_sel | input | CW | Per-channel result register select |
| res_data | output | RW | Selected per-channel result |
| cnv_start | output | 1 | Converter start pulse |
| cnv_chan | output | CW | Channel to convert |
| cnv_abort | output | 1 | Cancel the conversion in flight |
| cnv_done | input | 1 | Conversion finished |
| cnv_result | input | RW | Conversion result, valid with `cnv_done` |

## Verification
A start sampled at one clock edge marks the sequence active at that edge. `cnv_start` then rises combinationally in the cycle that follows. A `cnv_abort` for a preempting B start appears in the same cycle that the start is driven, and B's first `cnv_start` comes one cycle later. A `cnv_done` sampled at an edge updates the global register, the flags and the result register at that edge. The next `cnv_start` follows one cycle after that. The bench keeps a log of the starts and cancels seen at the ports. It compares that log with channel orders computed from the masks only once a wait has passed that is longer than the worst-case pass. Register outputs are read at the falling edge after the strobe that changes them.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int NSEQ = 2;
    localparam logic SEQ_A = 1'b0;
    localparam logic SEQ_B = 1'b1;
endpackage

// File: rtl/adc_seq_scan.sv
// Finds the lowest enabled channel at or above a start index, and the lowest
// enabled channel overall (used when the search wraps).
module adc_seq_scan #(
    parameter int NCH = 12,
    parameter int CW  = $clog2(NCH)
) (
    input  logic [NCH-1:0] mask,
    input  logic [CW:0]    from,
    output logic           hit_ge,
    output logic [CW-1:0]  idx_ge,
    output logic [CW-1:0]  idx_low
);
    always_comb begin
        hit_ge  = 1'b0;
        idx_ge  = '0;
        idx_low = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (mask[i]) begin
                idx_low = CW'(i);
                if ((CW+1)'(i) >= from) begin
                    hit_ge = 1'b1;
                    idx_ge = CW'(i);
                end
            end
        end
    end
endmodule

// File: rtl/adc_seq_resbank.sv
// Per-channel result registers with one write port and one read port.
module adc_seq_resbank #(
    parameter int NCH = 12,
    parameter int RW  = 12,
    parameter int CW  = $clog2(NCH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_ch,
    input  logic [RW-1:0] wr_data,
    input  logic [CW-1:0] rd_ch,
    output logic [RW-1:0] rd_data
);
    typedef logic [NCH-1:0][RW-1:0] bank_t;
    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_en && (int'(wr_ch) < NCH)) begin
            bank_d[wr_ch] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign rd_data = (int'(rd_ch) < NCH) ? bank_q[rd_ch] : '0;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
    parameter int NCH = 12,
    parameter int RW  = 12,
    parameter int CW  = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic           cfg_sel,
    input  logic [NCH-1:0] cfg_mask,
    input  logic           cfg_burst,
    input  logic           cfg_step,
    input  logic           cfg_hiprio,
    input  logic           cfg_eos,
    input  logic           start_a,
    input  logic           start_b,
    input  logic [1:0]     flag_clr,
    input  logic           gdat_sel,
    input  logic           gdat_rd,
    output logic [RW-1:0]  gdat_data,
    output logic [CW-1:0]  gdat_chan,
    output logic           gdat_valid,
    output logic           gdat_ovr,
    output logic [1:0]     seq_flag,
    output logic           ovr_irq,
    input  logic [CW-1:0]  res_sel,
    output logic [RW-1:0]  res_data,
    output logic           cnv_start,
    output logic [CW-1:0]  cnv_chan,
    output logic           cnv_abort,
    input  logic           cnv_done,
    input  logic [RW-1:0]  cnv_result
);
    import adc_seq_pkg::*;

    typedef struct packed {
        logic [NSEQ-1:0][NCH-1:0] mask;
        logic [NSEQ-1:0]          burst;
        logic [NSEQ-1:0]          step;
        logic [NSEQ-1:0]          eos;
        logic                     hiprio;
        logic [NSEQ-1:0]          active;
        logic [NSEQ-1:0][CW-1:0]  ptr;
        logic [NSEQ-1:0]          eflag;
        logic [NSEQ-1:0]          gvalid;
        logic [NSEQ-1:0]          govr;
        logic [NSEQ-1:0][RW-1:0]  gdata;
        logic [NSEQ-1:0][CW-1:0]  gchan;
        logic                     busy;
        logic                     own;
        logic [CW-1:0]            cur;
    } st_t;

    st_t d, q;

    logic [NSEQ-1:0]         start_v;
    logic [NSEQ-1:0]         go;
    logic [NSEQ-1:0]         sc_hit;
    logic [NSEQ-1:0][CW-1:0] sc_ge;
    logic [NSEQ-1:0][CW-1:0] sc_low;
    logic [NSEQ-1:0][CW-1:0] cur_idx;
    logic                    nx_hit;
    logic [CW-1:0]           nx_idx;
    logic [CW-1:0]           nx_low;
    logic [CW:0]             nx_from;
    logic                    done_ev;
    logic                    rb_we;
    logic                    sel_seq;
    logic                    sel_ok;

    // Signals brought out for the bound checker
    logic                    a_act;
    logic                    a_hp;
    logic [NSEQ-1:0]         mode_eos;

    assign start_v = {start_b, start_a};

    // Where each sequence would convert next (wrapping to its lowest channel)
    for (genvar s = 0; s < NSEQ; s++) begin : g_scan
        adc_seq_scan #(.NCH(NCH), .CW(CW)) u_scan (
            .mask    (q.mask[s]),
            .from    ({1'b0, q.ptr[s]}),
            .hit_ge  (sc_hit[s]),
            .idx_ge  (sc_ge[s]),
            .idx_low (sc_low[s])
        );
        assign cur_idx[s] = sc_hit[s] ? sc_ge[s] : sc_low[s];
    end

    // Channel after the one in flight, for the owning sequence
    assign nx_from = (CW+1)'({1'b0, q.cur}) + (CW+1)'(1);

    adc_seq_scan #(.NCH(NCH), .CW(CW)) u_next (
        .mask    (q.mask[q.own]),
        .from    (nx_from),
        .hit_ge  (nx_hit),
        .idx_ge  (nx_idx),
        .idx_low (nx_low)
    );

    always_comb begin
        d         = q;
        cnv_start = 1'b0;
        cnv_chan  = '0;
        cnv_abort = 1'b0;
        rb_we     = 1'b0;
        sel_seq   = SEQ_A;
        sel_ok    = 1'b0;
        go        = '0;
        done_ev   = q.busy && cnv_done;

        // Control writes
        if (cfg_we) begin
            d.mask[cfg_sel]  = cfg_mask;
            d.burst[cfg_sel] = cfg_burst;
            d.step[cfg_sel]  = cfg_step;
            d.eos[cfg_sel]   = cfg_eos;
            if (cfg_sel == SEQ_A) d.hiprio = cfg_hiprio;
        end

        // Global register read clears valid and overrun
        if (gdat_rd) begin
            d.gvalid[gdat_sel] = 1'b0;
            d.govr[gdat_sel]   = 1'b0;
        end

        // Per-pass flag clears (a same-cycle set below wins)
        for (int s = 0; s < NSEQ; s++) begin
            if (flag_clr[s]) d.eflag[s] = 1'b0;
        end

        // Conversion completion
        if (done_ev) begin
            rb_we             = 1'b1;
            d.gdata[q.own]    = cnv_result;
            d.gchan[q.own]    = q.cur;
            d.govr[q.own]     = d.govr[q.own] | d.gvalid[q.own];
            d.gvalid[q.own]   = 1'b1;
            d.busy            = 1'b0;
            if (nx_hit) begin
                d.ptr[q.own] = nx_idx;
                if (q.step[q.own]) d.active[q.own] = 1'b0;
            end else begin
                d.ptr[q.own]    = nx_low;
                d.active[q.own] = 1'b0;
                if (q.eos[q.own]) d.eflag[q.own] = 1'b1;
            end
        end

        // Pass activation: starts or burst re-arm, gated by mask and priority
        go[SEQ_A] = (|q.mask[SEQ_A]) && !q.active[SEQ_A]
                    && (q.burst[SEQ_A] || start_v[SEQ_A]);
        go[SEQ_B] = (|q.mask[SEQ_B]) && !q.active[SEQ_B]
                    && (q.burst[SEQ_B] || start_v[SEQ_B])
                    && (!q.active[SEQ_A] || q.hiprio);
        for (int s = 0; s < NSEQ; s++) begin
            if (go[s]) d.active[s] = 1'b1;
            if (q.active[s] && !(|q.mask[s]) && !(q.busy && (q.own == s[0])))
                d.active[s] = 1'b0;
        end

        // Preemption of an A conversion in flight
        if (go[SEQ_B] && q.active[SEQ_A] && q.busy && (q.own == SEQ_A) && !cnv_done) begin
            cnv_abort = 1'b1;
            d.busy    = 1'b0;
        end

        // Issue: B is served before A when both have work
        if (!q.busy) begin
            if (q.active[SEQ_B] && (|q.mask[SEQ_B])) begin
                sel_seq = SEQ_B;
                sel_ok  = 1'b1;
            end else if (q.active[SEQ_A] && (|q.mask[SEQ_A])) begin
                sel_seq = SEQ_A;
                sel_ok  = 1'b1;
            end
            if (sel_ok) begin
                cnv_start        = 1'b1;
                cnv_chan         = cur_idx[sel_seq];
                d.busy           = 1'b1;
                d.own            = sel_seq;
                d.cur            = cur_idx[sel_seq];
                d.ptr[sel_seq]   = cur_idx[sel_seq];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    adc_seq_resbank #(.NCH(NCH), .RW(RW), .CW(CW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (rb_we),
        .wr_ch   (q.cur),
        .wr_data (cnv_result),
        .rd_ch   (res_sel),
        .rd_data (res_data)
    );

    for (genvar s = 0; s < NSEQ; s++) begin : g_flag
        assign seq_flag[s] = q.eos[s] ? q.eflag[s] : q.gvalid[s];
    end

    assign ovr_irq    = |(q.govr & ~q.eos);
    assign gdat_data  = q.gdata[gdat_sel];
    assign gdat_chan  = q.gchan[gdat_sel];
    assign gdat_valid = q.gvalid[gdat_sel];
    assign gdat_ovr   = q.govr[gdat_sel];

    assign a_act    = q.active[SEQ_A];
    assign a_hp     = q.hiprio;
    assign mode_eos = q.eos;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cnv_start,
    input logic       cnv_abort,
    input logic       cnv_done,
    input logic       start_b,
    input logic       cfg_we,
    input logic [1:0] flag_clr,
    input logic [1:0] seq_flag,
    input logic       ovr_irq,
    input logic       a_act,
    input logic       a_hp,
    input logic [1:0] mode_eos
);
    assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_start |=> !cnv_start);

    assert_lowprio_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_b && a_act && !a_hp) |-> !cnv_abort);

    assert_abort_then_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnv_abort && !cfg_we) |=> cnv_start);

    assert_ovr_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_irq) |-> ($past(cnv_done) || $past(cfg_we)));

    assert_eos_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_flag[0] && mode_eos[0] && !flag_clr[0] && !cfg_we) |=> seq_flag[0]);

    assert_eos_hold_b_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_flag[1] && mode_eos[1] && !flag_clr[1] && !cfg_we) |=> seq_flag[1]);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnv_start(cnv_start),
    .cnv_abort(cnv_abort),
    .cnv_done (cnv_done),
    .start_b  (start_b),
    .cfg_we   (cfg_we),
    .flag_clr (flag_clr),
    .seq_flag (seq_flag),
    .ovr_irq  (ovr_irq),
    .a_act    (a_act),
    .a_hp     (a_hp),
    .mode_eos (mode_eos)
);

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
    localparam int NCH = 12;
    localparam int RW  = 12;
    localparam int CW  = 4;
    localparam int LAT = 4;
    localparam int ABORT_MARK = 15;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [NCH-1:0] cfg_mask = '0;
    logic           cfg_burst = 1'b0, cfg_step = 1'b0, cfg_hiprio = 1'b0, cfg_eos = 1'b0;
    logic           start_a = 1'b0, start_b = 1'b0;
    logic [1:0]     flag_clr = '0;
    logic           gdat_sel = 1'b0, gdat_rd = 1'b0;
    logic [RW-1:0]  gdat_data;
    logic [CW-1:0]  gdat_chan;
    logic           gdat_valid, gdat_ovr;
    logic [1:0]     seq_flag;
    logic           ovr_irq;
    logic [CW-1:0]  res_sel = '0;
    logic [RW-1:0]  res_data;
    logic           cnv_start, cnv_abort;
    logic [CW-1:0]  cnv_chan;
    logic           cnv_done = 1'b0;
    logic [RW-1:0]  cnv_result = '0;

    int n_chk = 0;
    int n_bad = 0;
    int log_ch [0:511];
    int n_log = 0;
    int exp_ch [0:511];
    int n_exp = 0;

    always #5 clk = ~clk;

    adc_seq_ctrl #(.NCH(NCH), .RW(RW), .CW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_mask(cfg_mask),
        .cfg_burst(cfg_burst), .cfg_step(cfg_step), .cfg_hiprio(cfg_hiprio), .cfg_eos(cfg_eos),
        .start_a(start_a), .start_b(start_b), .flag_clr(flag_clr),
        .gdat_sel(gdat_sel), .gdat_rd(gdat_rd),
        .gdat_data(gdat_data), .gdat_chan(gdat_chan), .gdat_valid(gdat_valid), .gdat_ovr(gdat_ovr),
        .seq_flag(seq_flag), .ovr_irq(ovr_irq),
        .res_sel(res_sel), .res_data(res_data),
        .cnv_start(cnv_start), .cnv_chan(cnv_chan), .cnv_abort(cnv_abort),
        .cnv_done(cnv_done), .cnv_result(cnv_result)
    );

    function automatic logic [RW-1:0] conv_val(input int ch);
        return RW'((ch * 293 + 77) % 4096);
    endfunction

    // Behavioural converter: fixed latency, cancel drops the pending result
    logic          pend = 1'b0;
    int            cnt = 0;
    logic [CW-1:0] pch = '0;
    always @(posedge clk) begin
        cnv_done <= 1'b0;
        if (cnv_abort) begin
            pend <= 1'b0;
        end else if (pend) begin
            if (cnt == 0) begin
                cnv_done   <= 1'b1;
                cnv_result <= conv_val(int'(pch));
                pend       <= 1'b0;
            end else begin
                cnt <= cnt - 1;
            end
        end
        if (cnv_start) begin
            pend <= 1'b1;
            cnt  <= LAT;
            pch  <= cnv_chan;
        end
    end

    // Port monitor: log of starts and cancels
    always @(posedge clk) begin
        if (rst_n && cnv_abort && n_log < 512) begin
            log_ch[n_log] = ABORT_MARK;
            n_log = n_log + 1;
        end
        if (rst_n && cnv_start && n_log < 512) begin
            log_ch[n_log] = int'(cnv_chan);
            n_log = n_log + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, expv);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        n_log = 0;
    endtask

    task automatic cfg(input bit sel, input logic [NCH-1:0] m,
                       input bit b, input bit st, input bit hp, input bit e);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_mask = m;
        cfg_burst = b; cfg_step = st; cfg_hiprio = hp; cfg_eos = e;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_a();
        @(negedge clk); start_a = 1'b1;
        @(negedge clk); start_a = 1'b0;
    endtask

    task automatic pulse_b();
        @(negedge clk); start_b = 1'b1;
        @(negedge clk); start_b = 1'b0;
    endtask

    task automatic read_gdat(input bit sel);
        @(negedge clk); gdat_sel = sel; gdat_rd = 1'b1;
        @(negedge clk); gdat_rd = 1'b0;
    endtask

    task automatic add_pass(input logic [NCH-1:0] m);
        for (int i = 0; i < NCH; i++) begin
            if (m[i]) begin exp_ch[n_exp] = i; n_exp++; end
        end
    endtask

    task automatic cmp_log(input string req);
        chk(n_log == n_exp, req, n_log, n_exp);
        for (int i = 0; i < n_exp && i < n_log; i++) begin
            chk(log_ch[i] == exp_ch[i], req, log_ch[i], exp_ch[i]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog: act=timeout exp=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [NCH-1:0] m;
        int keep;
        // R1: reset state
        do_reset();
        @(negedge clk);
        chk(cnv_start == 1'b0, "R1 start", int'(cnv_start), 0);
        chk(seq_flag == 2'b00, "R1 flags", int'(seq_flag), 0);
        chk(ovr_irq == 1'b0, "R1 ovr_irq", int'(ovr_irq), 0);
        chk(gdat_valid == 1'b0 && gdat_ovr == 1'b0, "R1 gdat", int'({gdat_valid, gdat_ovr}), 0);
        // R1/R3: reset mask is empty, so a start does nothing
        pulse_a();
        repeat (20) @(negedge clk);
        chk(n_log == 0, "R1 R3 empty mask start", n_log, 0);

        // R2/R12/R11: mask sweep, per-pass flag mode
        for (int k = 1; k <= 24; k++) begin
            m = NCH'((k * 12'h1A7) ^ (k << 3));
            if (m == '0) m = NCH'(k);
            do_reset();
            cfg(1'b0, m, 1'b0, 1'b0, 1'b0, 1'b1);
            n_exp = 0;
            add_pass(m);
            pulse_a();
            repeat (10 * n_exp + 20) @(negedge clk);
            cmp_log("R2 order");
            chk(seq_flag[0] == 1'b1, "R11 pass flag", int'(seq_flag[0]), 1);
            for (int c = 0; c < NCH; c++) begin
                if (m[c]) begin
                    res_sel = CW'(c);
                    #1;
                    chk(res_data == conv_val(c), "R12 channel result", int'(res_data), int'(conv_val(c)));
                end
            end
        end

        // R4: second start during the pass is ignored
        do_reset();
        cfg(1'b0, 12'h00F, 1'b0, 1'b0, 1'b0, 1'b0);
        n_exp = 0; add_pass(12'h00F);
        pulse_a();
        repeat (10) @(negedge clk);
        pulse_a();
        repeat (60) @(negedge clk);
        cmp_log("R4 restart ignored");

        // R9/R10: per-conversion mode
        do_reset();
        cfg(1'b0, 12'h010, 1'b0, 1'b0, 1'b0, 1'b0);
        pulse_a();
        repeat (30) @(negedge clk);
        gdat_sel = 1'b0; #1;
        chk(gdat_valid == 1'b1, "R9 valid", int'(gdat_valid), 1);
        chk(gdat_chan == 4, "R9 chan", int'(gdat_chan), 4);
        chk(gdat_data == conv_val(4), "R9 data", int'(gdat_data), int'(conv_val(4)));
        chk(gdat_ovr == 1'b0, "R9 no overrun", int'(gdat_ovr), 0);
        chk(seq_flag[0] == 1'b1, "R10 flag follows valid", int'(seq_flag[0]), 1);
        read_gdat(1'b0);
        chk(gdat_valid == 1'b0, "R9 read clears", int'(gdat_valid), 0);
        chk(seq_flag[0] == 1'b0, "R10 flag cleared by read", int'(seq_flag[0]), 0);
        cfg(1'b0, 12'h030, 1'b0, 1'b0, 1'b0, 1'b0);
        pulse_a();
        repeat (40) @(negedge clk);
        chk(gdat_ovr == 1'b1, "R9 overrun", int'(gdat_ovr), 1);
        chk(gdat_chan == 5, "R9 last chan", int'(gdat_chan), 5);
        chk(ovr_irq == 1'b1, "R10 overrun irq", int'(ovr_irq), 1);
        read_gdat(1'b0);
        chk(gdat_ovr == 1'b0 && ovr_irq == 1'b0, "R9 R10 read clears overrun", int'({gdat_ovr, ovr_irq}), 0);

        // R11: per-pass mode, overrun excluded, flag held until cleared
        do_reset();
        cfg(1'b0, 12'h030, 1'b0, 1'b0, 1'b0, 1'b1);
        pulse_a();
        repeat (40) @(negedge clk);
        gdat_sel = 1'b0; #1;
        chk(gdat_ovr == 1'b1, "R11 overrun recorded", int'(gdat_ovr), 1);
        chk(ovr_irq == 1'b0, "R11 overrun excluded", int'(ovr_irq), 0);
        read_gdat(1'b0);
        repeat (10) @(negedge clk);
        chk(seq_flag[0] == 1'b1, "R11 flag held", int'(seq_flag[0]), 1);
        @(negedge clk); flag_clr = 2'b01;
        @(negedge clk); flag_clr = 2'b00;
        chk(seq_flag[0] == 1'b0, "R11 flag cleared", int'(seq_flag[0]), 0);

        // R6: stepping with per-pass flag
        do_reset();
        cfg(1'b0, 12'h0A4, 1'b0, 1'b1, 1'b0, 1'b1);
        pulse_a(); repeat (20) @(negedge clk);
        pulse_a(); repeat (20) @(negedge clk);
        chk(n_log == 2, "R6 one per start", n_log, 2);
        chk(seq_flag[0] == 1'b0, "R6 R11 no flag mid pass", int'(seq_flag[0]), 0);
        pulse_a(); repeat (20) @(negedge clk);
        chk(seq_flag[0] == 1'b1, "R6 R11 flag at last step", int'(seq_flag[0]), 1);
        pulse_a(); repeat (20) @(negedge clk);
        n_exp = 0; add_pass(12'h0A4); exp_ch[3] = 2; n_exp = 4;
        cmp_log("R6 step order");

        // R5: burst, start ignored, clear lets pass finish
        do_reset();
        cfg(1'b0, 12'h003, 1'b1, 1'b0, 1'b0, 1'b0);
        repeat (30) @(negedge clk);
        pulse_a();
        repeat (50) @(negedge clk);
        cfg(1'b0, 12'h003, 1'b0, 1'b0, 1'b0, 1'b0);
        repeat (40) @(negedge clk);
        keep = n_log;
        chk(n_log >= 6, "R5 repeated passes", n_log, 6);
        for (int i = 0; i < n_log; i++) begin
            chk(log_ch[i] == i % 2, "R5 pass pattern", log_ch[i], i % 2);
        end
        repeat (40) @(negedge clk);
        chk(n_log == keep, "R5 stopped after clear", n_log, keep);

        // R7: low priority, B start discarded
        do_reset();
        cfg(1'b0, 12'hFFF, 1'b0, 1'b0, 1'b0, 1'b0);
        cfg(1'b1, 12'h006, 1'b0, 1'b0, 1'b0, 1'b0);
        pulse_a();
        while (n_log < 3) @(negedge clk);
        pulse_b();
        repeat (150) @(negedge clk);
        n_exp = 0; add_pass(12'hFFF);
        cmp_log("R7 B discarded");
        gdat_sel = 1'b1; #1;
        chk(gdat_valid == 1'b0, "R7 B converted nothing", int'(gdat_valid), 0);

        // R8: high priority, cancel, B pass, A resumes at cancelled channel
        do_reset();
        cfg(1'b0, 12'hFFF, 1'b0, 1'b0, 1'b1, 1'b0);
        cfg(1'b1, 12'h006, 1'b0, 1'b0, 1'b0, 1'b0);
        pulse_a();
        while (n_log < 3) @(negedge clk);
        pulse_b();
        repeat (170) @(negedge clk);
        n_exp = 0;
        add_pass(12'h007);
        exp_ch[n_exp] = ABORT_MARK; n_exp++;
        add_pass(12'h006);
        add_pass(12'hFFC);
        cmp_log("R8 preempt order");
        gdat_sel = 1'b1; #1;
        chk(gdat_valid == 1'b1 && gdat_chan == 2, "R8 B result", int'(gdat_chan), 2);

        // R3: B with empty mask
        do_reset();
        pulse_b();
        repeat (20) @(negedge clk);
        chk(n_log == 0, "R3 B empty mask", n_log, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule